// File: doc/BRIEF.md
# Card Slot Power Sequencer

This block brings the contact lines of a card slot up and down in a fixed order whenever the slot's enable changes level. It owns the slot regulator enable and three release controls, one each for the card reset, data and clock lines. While a release is low, the downstream level shifter drives that line low. It also gives the signal router a ready flag, which is high only when the whole slot is live. Several slots can be instantiated side by side, and each one sequences on its own. All slots share one sampled copy of the free-running card clock.

On activation the slot first holds every card line low for one cycle and then turns the regulator on. When the regulator reports power-good, data and reset are released together. The clock is released only after two rising card-clock edges have been counted. On deactivation the order runs the other way. Reset drops at once. The clock is forced low after two more card-clock edges, or when the wind-down window expires if the card clock has stopped. Data is forced low when that window ends, and the regulator is turned off one cycle after data. A regulator that never reports power-good aborts activation and raises a sticky fault.

Top module: `card_slot_seq`

## Requirements
- R1: In the cycle after the enable is first sampled high, the regulator enable and all three release controls are low. The regulator enable rises one cycle later, while the releases are still low.
- R2: Data and reset releases rise together in the cycle after power-good is sampled high during the power-wait phase. The clock release stays low at that point.
- R3: The clock release and the ready flag rise after the second card-clock rising edge that follows data release. A card-clock edge reaches the decision logic through SYNC_STAGES sampling flops plus one edge flop.
- R4: When the enable is sampled low while the slot is ready, the reset release and the ready flag drop in the next cycle. The data release stays high at that point.
- R5: During wind-down, the clock release is forced low after the second card-clock rising edge that follows the enable fall. If the card clock has stopped, it is forced low when the wind-down window ends.
- R6: The data release falls DEACT_CYC cycles after the edge that sampled the enable low. The regulator enable falls exactly one cycle after that.
- R7: If power-good is not seen within PG_TIMEOUT cycles of the regulator turning on, the fault flag is set. Data stays low, and the regulator is turned off one cycle later. The fault flag then holds until reset.
- R8: If the enable falls during activation, deactivation starts at once. From power-wait, the regulator is turned off one cycle later. From the clock-wait phase, the clock stays low and the wind-down runs in full.
- R9: Each slot sequences independently of the others, on its own enable and power-good.
- R10: During reset, every output is low.
- R11: If the enable rises again during wind-down, the wind-down completes first, and then a fresh activation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that sets all timing |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_clk | input | 1 | Free-running card clock, sampled as a signal |
| slot_en | input | NCH | Per-slot enable |
| pwr_good | input | NCH | Per-slot regulator power-good |
| reg_en | output | NCH | Per-slot regulator enable |
| card_rst_rel | output | NCH | Reset line release (0 = forced low) |
| card_data_rel | output | NCH | Data line release (0 = forced low) |
| card_clk_rel | output | NCH | Clock line release (0 = forced low) |
| slot_ready | output | NCH | Slot fully active, for the signal router |
| pg_fault | output | NCH | Sticky power-good timeout flag |

## Verification
A wrong phase register shows up as a release pattern that no legal phase produces. Examples are a clock release while data is held low, or a regulator turning off while data is still released. Such patterns appear in the very cycle the state goes wrong. A wrong edge count or a wrong clock-hold bit shows within a few card-clock periods, as an early or late change of the clock release. A wrong wind-down or timeout counter only shows when that window ends: data or the regulator drops on the wrong cycle, DEACT_CYC or PG_TIMEOUT cycles after the trigger. For that reason the bench keeps both windows short and measures their exact length.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_HOLD,
    PH_POWER,
    PH_LINK,
    PH_ON,
    PH_DEACT,
    PH_DRAIN
  } phase_t;

  typedef struct packed {
    logic reg_en;
    logic rst_rel;
    logic data_rel;
    logic clk_rel;
    logic ready;
  } slot_out_t;

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // line controls implied by a phase; clk_hold forces the clock low in wind-down
  function automatic slot_out_t phase_outputs(input phase_t ph, input logic clk_hold);
    slot_out_t o;
    o.reg_en   = (ph == PH_POWER) || (ph == PH_LINK) || (ph == PH_ON) ||
                 (ph == PH_DEACT) || (ph == PH_DRAIN);
    o.rst_rel  = (ph == PH_LINK) || (ph == PH_ON);
    o.data_rel = (ph == PH_LINK) || (ph == PH_ON) || (ph == PH_DEACT);
    o.clk_rel  = (ph == PH_ON) || ((ph == PH_DEACT) && !clk_hold);
    o.ready    = (ph == PH_ON);
    return o;
  endfunction

endpackage

// File: rtl/card_edge_sync.sv
module card_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int unsigned LEN = (STAGES < 2) ? 2 : STAGES;

  logic [LEN:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LEN-1:0], din};
  end

  assign rise = chain[LEN-1] & ~chain[LEN];
endmodule

// File: rtl/card_tick_counter.sv
module card_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clear) value <= '0;
    else if (inc)   value <= value + W'(1);
  end
endmodule

// File: rtl/card_chan_fsm.sv
module card_chan_fsm
  import cardseq_pkg::*;
#(
  parameter int unsigned DEACT_CYC  = 1800,
  parameter int unsigned PG_TIMEOUT = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwr_good,
  input  logic cc_rise,
  output logic reg_en,
  output logic rst_rel,
  output logic data_rel,
  output logic clk_rel,
  output logic ready,
  output logic fault
);
  localparam int unsigned TW = cnt_width(max_u(DEACT_CYC, PG_TIMEOUT));

  phase_t     state, nxt;
  logic [TW-1:0] tick;
  logic [1:0] edges;
  logic       clk_hold;
  logic       pg_expired;
  logic       tick_last_pg, tick_last_dc, second_rise, phase_change;
  logic       tick_inc, edge_inc;
  slot_out_t  lines;

  assign tick_last_pg = (tick == TW'(PG_TIMEOUT - 1));
  assign tick_last_dc = (tick == TW'(DEACT_CYC - 1));
  assign second_rise  = cc_rise && (edges == 2'd1);

  always_comb begin
    nxt        = state;
    pg_expired = 1'b0;
    unique case (state)
      PH_OFF:   if (en) nxt = PH_HOLD;
      PH_HOLD:  nxt = en ? PH_POWER : PH_OFF;
      PH_POWER: begin
        if (!en)               nxt = PH_DRAIN;
        else if (pwr_good)     nxt = PH_LINK;
        else if (tick_last_pg) begin
          nxt        = PH_DRAIN;
          pg_expired = 1'b1;
        end
      end
      PH_LINK:  begin
        if (!en)              nxt = PH_DEACT;
        else if (second_rise) nxt = PH_ON;
      end
      PH_ON:    if (!en) nxt = PH_DEACT;
      PH_DEACT: if (tick_last_dc) nxt = PH_DRAIN;
      PH_DRAIN: nxt = PH_OFF;
      default:  nxt = PH_OFF;
    endcase
  end

  assign phase_change = (nxt != state);
  assign tick_inc     = (state == PH_POWER) || (state == PH_DEACT);
  assign edge_inc     = cc_rise && (edges != 2'd3) &&
                        ((state == PH_LINK) || (state == PH_DEACT));

  card_tick_counter #(.W(TW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_change),
    .inc   (tick_inc),
    .value (tick)
  );

  card_tick_counter #(.W(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_change),
    .inc   (edge_inc),
    .value (edges)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_OFF;
    else        state <= nxt;
  end

  // clock stays low in wind-down if it was never released, or after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  clk_hold <= 1'b0;
    else if (state != PH_DEACT && nxt == PH_DEACT) clk_hold <= (state == PH_LINK);
    else if (state == PH_DEACT && second_rise)   clk_hold <= 1'b1;
    else if (state != PH_DEACT)                  clk_hold <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault <= 1'b0;
    else if (pg_expired) fault <= 1'b1;
  end

  assign lines    = phase_outputs(state, clk_hold);
  assign reg_en   = lines.reg_en;
  assign rst_rel  = lines.rst_rel;
  assign data_rel = lines.data_rel;
  assign clk_rel  = lines.clk_rel;
  assign ready    = lines.ready;
endmodule

// File: rtl/card_slot_seq.sv
module card_slot_seq #(
  parameter int unsigned NCH         = 2,
  parameter int unsigned DEACT_CYC   = 1800,
  parameter int unsigned PG_TIMEOUT  = 400000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           card_clk,
  input  logic [NCH-1:0] slot_en,
  input  logic [NCH-1:0] pwr_good,
  output logic [NCH-1:0] reg_en,
  output logic [NCH-1:0] card_rst_rel,
  output logic [NCH-1:0] card_data_rel,
  output logic [NCH-1:0] card_clk_rel,
  output logic [NCH-1:0] slot_ready,
  output logic [NCH-1:0] pg_fault
);
  logic cc_rise;

  card_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (card_clk),
    .rise  (cc_rise)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_slot
    card_chan_fsm #(
      .DEACT_CYC  (DEACT_CYC),
      .PG_TIMEOUT (PG_TIMEOUT)
    ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (slot_en[ch]),
      .pwr_good (pwr_good[ch]),
      .cc_rise  (cc_rise),
      .reg_en   (reg_en[ch]),
      .rst_rel  (card_rst_rel[ch]),
      .data_rel (card_data_rel[ch]),
      .clk_rel  (card_clk_rel[ch]),
      .ready    (slot_ready[ch]),
      .fault    (pg_fault[ch])
    );
  end
endmodule

// File: rtl/card_slot_seq_chk.sv
module card_slot_seq_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] slot_en,
  input logic [NCH-1:0] pwr_good,
  input logic [NCH-1:0] reg_en,
  input logic [NCH-1:0] card_rst_rel,
  input logic [NCH-1:0] card_data_rel,
  input logic [NCH-1:0] card_clk_rel,
  input logic [NCH-1:0] slot_ready,
  input logic [NCH-1:0] pg_fault
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_POWER_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_en[i]) |-> $past(!card_data_rel[i] && !card_rst_rel[i] && !card_clk_rel[i])); // R1
    AST_DATA_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_data_rel[i]) |-> $past(pwr_good[i]) && card_rst_rel[i] && reg_en[i]); // R2
    AST_CLK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_clk_rel[i]) |-> $past(card_data_rel[i])); // R3
    AST_RST_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_en[i] && slot_ready[i]) |=> !card_rst_rel[i] && !slot_ready[i]); // R4
    AST_NO_CLK_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !card_data_rel[i] |-> !card_clk_rel[i]); // R5
    AST_REG_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_en[i]) |-> $past(!card_data_rel[i])); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pg_fault[i] |=> pg_fault[i]); // R7
    AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_fault[i]) |-> $past(!pwr_good[i]) && !card_data_rel[i] && reg_en[i]); // R7
  end
endmodule

bind card_slot_seq card_slot_seq_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .slot_en       (slot_en),
  .pwr_good      (pwr_good),
  .reg_en        (reg_en),
  .card_rst_rel  (card_rst_rel),
  .card_data_rel (card_data_rel),
  .card_clk_rel  (card_clk_rel),
  .slot_ready    (slot_ready),
  .pg_fault      (pg_fault)
);

// File: tb/sim_card_slot_seq.sv
`timescale 1ns/1ps
module sim_card_slot_seq;
  localparam int NCH = 2;
  localparam int DC  = 40;
  localparam int PGT = 60;
  localparam int IDLE = 0, PRE = 1, RAMP = 2, HANDSHAKE = 3, LIVE = 4, WIND = 5, DROP = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic card_clk = 1'b0;
  logic [NCH-1:0] en = '0, pg = '0;
  logic [NCH-1:0] reg_en, rst_rel, data_rel, clk_rel, ready, fault;

  card_slot_seq #(.NCH(NCH), .DEACT_CYC(DC), .PG_TIMEOUT(PGT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .slot_en(en), .pwr_good(pg),
    .reg_en(reg_en), .card_rst_rel(rst_rel), .card_data_rel(data_rel),
    .card_clk_rel(clk_rel), .slot_ready(ready), .pg_fault(fault));

  int total = 0, bad = 0;
  int cc_half = 0, cc_cnt = 0;
  int pg_delay [NCH];
  int on_cnt [NCH];

  // reference model state
  int m_ph [NCH], m_t [NCH], m_r [NCH];
  bit m_hold [NCH], m_fault [NCH];
  bit h1, h2, h3;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // card clock and regulator stand-in, both driven on the falling edge
  initial begin
    for (int c = 0; c < NCH; c++) begin pg_delay[c] = 10; on_cnt[c] = 0; end
    forever begin
      @(negedge clk);
      if (cc_half > 0) begin
        cc_cnt++;
        if (cc_cnt >= cc_half) begin cc_cnt = 0; card_clk = ~card_clk; end
      end
      for (int c = 0; c < NCH; c++) begin
        if (!reg_en[c]) on_cnt[c] = 0; else on_cnt[c]++;
        pg[c] = reg_en[c] && (on_cnt[c] >= pg_delay[c]);
      end
    end
  end

  // behavioural reference, stepped on each rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        for (int c = 0; c < NCH; c++) begin
          m_ph[c] = IDLE; m_t[c] = 0; m_r[c] = 0; m_hold[c] = 0; m_fault[c] = 0;
        end
        h1 = 0; h2 = 0; h3 = 0;
      end else begin
        bit rise;
        rise = h2 && !h3;
        for (int c = 0; c < NCH; c++) begin
          case (m_ph[c])
            IDLE: if (en[c]) m_ph[c] = PRE;
            PRE: begin m_t[c] = 0; m_ph[c] = en[c] ? RAMP : IDLE; end
            RAMP: begin
              if (!en[c]) m_ph[c] = DROP;
              else if (pg[c]) begin m_ph[c] = HANDSHAKE; m_r[c] = 0; end
              else if (m_t[c] == PGT - 1) begin m_ph[c] = DROP; m_fault[c] = 1; end
              else m_t[c]++;
            end
            HANDSHAKE: begin
              if (!en[c]) begin m_ph[c] = WIND; m_t[c] = 0; m_r[c] = 0; m_hold[c] = 1; end
              else if (rise) begin m_r[c]++; if (m_r[c] == 2) m_ph[c] = LIVE; end
            end
            LIVE: if (!en[c]) begin m_ph[c] = WIND; m_t[c] = 0; m_r[c] = 0; m_hold[c] = 0; end
            WIND: begin
              if (rise) begin m_r[c]++; if (m_r[c] == 2) m_hold[c] = 1; end
              if (m_t[c] == DC - 1) m_ph[c] = DROP; else m_t[c]++;
            end
            default: m_ph[c] = IDLE;
          endcase
        end
        h3 = h2; h2 = h1; h1 = card_clk;
      end
    end
  end

  // compare every cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int c = 0; c < NCH; c++) begin
          int p;
          p = m_ph[c];
          chk("R1", $sformatf("ch%0d reg_en", c), reg_en[c],
              (p == RAMP || p == HANDSHAKE || p == LIVE || p == WIND || p == DROP) ? 1 : 0);
          chk("R2", $sformatf("ch%0d rst_rel", c), rst_rel[c], (p == HANDSHAKE || p == LIVE) ? 1 : 0);
          chk("R6", $sformatf("ch%0d data_rel", c), data_rel[c],
              (p == HANDSHAKE || p == LIVE || p == WIND) ? 1 : 0);
          chk("R5", $sformatf("ch%0d clk_rel", c), clk_rel[c],
              (p == LIVE || (p == WIND && !m_hold[c])) ? 1 : 0);
          chk("R3", $sformatf("ch%0d ready", c), ready[c], (p == LIVE) ? 1 : 0);
          chk("R7", $sformatf("ch%0d fault", c), fault[c], m_fault[c] ? 1 : 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_ready(input int c);
    while (!ready[c]) @(negedge clk);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "outputs in reset", {reg_en, rst_rel, data_rel, clk_rel, ready, fault}, 0);
    rst_n = 1'b1;
    cc_half = 3;
    repeat (3) @(negedge clk);

    // R1 hold then power
    en[0] = 1'b1;
    @(negedge clk);
    chk("R1", "hold cycle reg_en", reg_en[0], 0);
    @(negedge clk);
    chk("R1", "regulator on", reg_en[0], 1);
    chk("R1", "lines low at power on", {rst_rel[0], data_rel[0], clk_rel[0]}, 0);
    chk("R9", "other slot idle", reg_en[1], 0);
    while (!data_rel[0]) @(negedge clk);
    chk("R2", "reset with data", rst_rel[0], 1);
    chk("R2", "clock still held", clk_rel[0], 0);
    wait_ready(0);
    chk("R3", "clock released when ready", clk_rel[0], 1);

    // R4/R5/R6 wind-down with running clock
    en[0] = 1'b0;
    n = 0;
    @(negedge clk); n++;
    chk("R4", "reset dropped", rst_rel[0], 0);
    chk("R4", "data kept", data_rel[0], 1);
    while (clk_rel[0]) begin @(negedge clk); n++; end
    chk("R5", "clock stop before window end", (n < DC) ? 1 : 0, 1);
    while (data_rel[0]) begin @(negedge clk); n++; end
    chk("R6", "data low after window", n, DC + 1);
    chk("R6", "regulator still on with data low", reg_en[0], 1);
    @(negedge clk);
    chk("R6", "regulator off next cycle", reg_en[0], 0);

    // R5 fallback with a stopped card clock
    repeat (3) @(negedge clk);
    en[0] = 1'b1;
    wait_ready(0);
    cc_half = 0;
    repeat (10) @(negedge clk);
    en[0] = 1'b0;
    n = 0;
    while (clk_rel[0]) begin @(negedge clk); n++; end
    chk("R5", "stopped clock fallback", n, DC + 1);
    while (reg_en[0]) @(negedge clk);

    // R8 abort while waiting for card-clock edges
    repeat (3) @(negedge clk);
    en[0] = 1'b1;
    while (!data_rel[0]) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R3", "no clock without edges", clk_rel[0], 0);
    en[0] = 1'b0;
    @(negedge clk);
    chk("R8", "abort drops reset", rst_rel[0], 0);
    chk("R8", "abort keeps clock low", clk_rel[0], 0);
    n = 1;
    while (data_rel[0]) begin @(negedge clk); n++; end
    chk("R8", "abort still runs full window", n, DC + 1);
    while (reg_en[0]) @(negedge clk);

    // R7 power-good timeout on slot 1
    cc_half = 2;
    pg_delay[1] = 1000;
    en[1] = 1'b1;
    n = 0;
    while (!fault[1]) begin @(negedge clk); n++; end
    chk("R7", "timeout length", n, PGT + 2);
    chk("R7", "data low on timeout", data_rel[1], 0);
    @(negedge clk);
    chk("R7", "regulator off after timeout", reg_en[1], 0);
    en[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7", "fault sticky", fault[1], 1);
    chk("R9", "other slot no fault", fault[0], 0);

    // R8 abort during power wait
    pg_delay[0] = 30;
    en[0] = 1'b1;
    while (!reg_en[0]) @(negedge clk);
    repeat (3) @(negedge clk);
    en[0] = 1'b0;
    seen = 0;
    n = 0;
    while (reg_en[0]) begin @(negedge clk); n++; seen |= data_rel[0]; end
    chk("R8", "power-wait abort regulator off", n, 2);
    chk("R8", "data never released", seen, 0);

    // R9 both slots, different power-good delays
    pg_delay[0] = 50; pg_delay[1] = 5;
    en = 2'b11;
    wait_ready(1);
    chk("R9", "slot0 still waiting", data_rel[0], 0);
    wait_ready(0);
    chk("R9", "slot1 still ready", ready[1], 1);

    // R11 re-enable during wind-down
    en[0] = 1'b0;
    repeat (5) @(negedge clk);
    en[0] = 1'b1;
    n = 5;
    while (data_rel[0]) begin @(negedge clk); n++; end
    chk("R11", "wind-down completes", n, DC + 1);
    wait_ready(0);
    chk("R11", "reactivated", ready[0], 1);
    en = 2'b00;
    repeat (DC + 10) @(negedge clk);
    chk("R10", "all slots off", {reg_en, data_rel}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule